// File: doc/BRIEF.md
# Cascade Interrupt Acknowledge Sequencer

This block steps a programmable interrupt controller through the multi-pulse interrupt acknowledge cycle when several controllers are cascaded. A master can serve up to eight slaves over a 3-bit cascade address bus, which gives up to 64 priority levels in total. The block counts acknowledge pulses and latches the winning request level at the start of a sequence. As a master, it puts the number of a slave-attached winning input on the cascade bus. As a slave, it compares the cascade bus with its own identity and drives its vector bytes only when the two match.

The sequence has three pulses in 80/85 processor mode and two pulses in 86 mode. In 80/85 mode the master drives a CALL opcode on the first byte. The vector bytes come from two byte inputs supplied by the surrounding controller, and priority resolution is done outside the block. A buffer-enable output follows the data-bus drive whenever buffered operation is selected. `ack_n` is sampled by the clock, while the data outputs follow the low phase of `ack_n` combinationally.

Top module: `cascade_ack_seq`

## Requirements
- R1: After reset, `cas_out`, `data_oe`, `data_out` and `buf_en` are all zero.
- R2: A master loads the latched winning level onto `cas_out` at the rising edge of the first acknowledge pulse, but only when `slave_mask[win_level]` is 1. The winning level is latched at the falling edge of the first pulse.
- R3: `cas_out` returns to 0 at the rising edge of the final pulse. The final pulse is the third in 80/85 mode (`mode86`=0) and the second in 86 mode (`mode86`=1). `cas_out` keeps its value between those two edges.
- R4: When the winning input has no slave attached, a master keeps `cas_out` at 0 for the whole sequence.
- R5: In 80/85 mode a master drives 0xCD on `data_out` with `data_oe`=1 while `ack_n` is low during pulse 1.
- R6: A master whose winning input has no slave attached drives `vec_b2` on pulse 2, and in 80/85 mode also drives `vec_b3` on pulse 3. In 86 mode nothing is driven on pulse 1.
- R7: A master whose winning input has a slave attached drives nothing on pulses 2 and 3.
- R8: A slave (`is_master`=0) drives `vec_b2` on pulse 2 and, in 80/85 mode, `vec_b3` on pulse 3, only when `cas_in` equals `own_id`. It never drives on pulse 1, and it drives nothing when the two differ.
- R9: `buf_en` equals `data_oe` when `buffered`=1, and it is 0 when `buffered`=0.
- R10: A one-cycle `init_wr` clears the pulse count and `cas_out`, so the next pulse is treated as pulse 1.
- R11: `data_out` is 0 whenever `data_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_wr | input | 1 | Initialization write strobe; restarts the sequence |
| ack_n | input | 1 | Interrupt acknowledge strobe, active low |
| mode86 | input | 1 | 1 selects the two-pulse 86 sequence, 0 the three-pulse 80/85 sequence |
| is_master | input | 1 | 1 for the master role, 0 for the slave role |
| buffered | input | 1 | Buffered-bus operation enable |
| slave_mask | input | 8 | Bit n set means a slave is attached to request input n |
| own_id | input | 3 | This controller's slave identity |
| win_level | input | 3 | Winning request level from priority resolution |
| cas_in | input | 3 | Cascade bus as seen by a slave |
| vec_b2 | input | 8 | Vector byte for acknowledge byte 2 |
| vec_b3 | input | 8 | Vector byte for acknowledge byte 3 |
| cas_out | output | 3 | Cascade address driven by a master |
| data_oe | output | 1 | Data bus output enable |
| data_out | output | 8 | Data bus value |
| buf_en | output | 1 | External buffer enable |

## Verification
The data outputs (`data_oe`, `data_out`, `buf_en`) are combinational from `ack_n` and the registered pulse count. The bench therefore reads them one full clock period after it pulls `ack_n` low, still inside the pulse. `cas_out` and the pulse count change at the first clock edge after `ack_n` goes high, so the bench reads them one period after it releases the strobe. An `init_wr` takes effect at the next edge and is checked one period after it is applied. Every sample is taken on the falling clock edge, half a period away from any register update.

// File: rtl/cas_ack_pkg.sv
package cas_ack_pkg;
  localparam int unsigned CAS_W   = 3;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned IDX_W   = 2;
  localparam logic [7:0]  CALL_OP = 8'hCD;

  typedef logic [IDX_W-1:0] byte_idx_t;

  localparam byte_idx_t IDX_FIRST  = 2'd0;
  localparam byte_idx_t IDX_SECOND = 2'd1;
  localparam byte_idx_t IDX_THIRD  = 2'd2;
endpackage

// File: rtl/ack_pulse_tracker.sv
module ack_pulse_tracker
  import cas_ack_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ack_n,
  input  logic      init_wr,
  input  logic      mode86,
  output logic      ack_fall,
  output logic      ack_rise,
  output byte_idx_t byte_idx,
  output logic      seq_done
);
  logic      ack_q, ack_q_nxt;
  byte_idx_t cnt_q, cnt_nxt;
  byte_idx_t last_idx;
  logic      cnt_en;

  assign last_idx = mode86 ? IDX_SECOND : IDX_THIRD;
  assign ack_fall = ack_q & ~ack_n;
  assign ack_rise = ~ack_q & ack_n;
  assign seq_done = ack_rise & (cnt_q >= last_idx);
  assign cnt_en   = init_wr | ack_rise;

  always_comb begin
    ack_q_nxt = ack_n;
    cnt_nxt   = cnt_q;
    if (init_wr || seq_done) cnt_nxt = IDX_FIRST;
    else if (ack_rise)       cnt_nxt = cnt_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b1;
      cnt_q <= IDX_FIRST;
    end else begin
      ack_q <= ack_q_nxt;
      if (cnt_en) cnt_q <= cnt_nxt;
    end
  end

  assign byte_idx = cnt_q;

  // R3: the count never passes the last pulse of either sequence length
  assert_cnt_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q != 2'd3);

  // R10: an initialization write restarts the count
  assert_init_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    init_wr |=> byte_idx == IDX_FIRST);
endmodule

// File: rtl/cas_addr_master.sv
module cas_addr_master
  import cas_ack_pkg::*;
#(
  parameter int unsigned CAS_BITS = CAS_W,
  localparam int unsigned NUM_IN  = 1 << CAS_BITS
)(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                is_master,
  input  logic                init_wr,
  input  logic                ack_fall,
  input  logic                ack_rise,
  input  logic                seq_done,
  input  byte_idx_t           byte_idx,
  input  logic [CAS_BITS-1:0] win_level,
  input  logic [NUM_IN-1:0]   slave_mask,
  output logic [CAS_BITS-1:0] cas_out,
  output logic                win_has_slave
);
  logic [CAS_BITS-1:0] win_q, win_nxt;
  logic [CAS_BITS-1:0] cas_q, cas_nxt;
  logic                win_en, cas_en;
  logic                first_rise;

  assign first_rise    = ack_rise & (byte_idx == IDX_FIRST);
  assign win_en        = ack_fall & (byte_idx == IDX_FIRST);
  assign cas_en        = init_wr | seq_done | first_rise;
  assign win_has_slave = slave_mask[win_q];

  always_comb begin
    win_nxt = win_level;
    cas_nxt = '0;
    if (!(init_wr || seq_done) && first_rise && is_master && win_has_slave)
      cas_nxt = win_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      cas_q <= '0;
    end else begin
      if (win_en) win_q <= win_nxt;
      if (cas_en) cas_q <= cas_nxt;
    end
  end

  assign cas_out = cas_q;

  // R3: the cascade bus is released when the final pulse ends
  assert_cas_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> cas_out == '0);

  // R4: no slave on the winning input keeps the bus idle
  assert_cas_nomask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (first_rise && !win_has_slave && cas_out == '0) |=> cas_out == '0);

  // R3: the address holds between the first and the final rising edges
  assert_cas_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_rise && !init_wr) |=> $stable(cas_out));
endmodule

// File: rtl/ack_data_driver.sv
module ack_data_driver
  import cas_ack_pkg::*;
#(
  parameter int unsigned CAS_BITS  = CAS_W,
  parameter int unsigned DATA_BITS = DATA_W
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ack_n,
  input  byte_idx_t            byte_idx,
  input  logic                 mode86,
  input  logic                 is_master,
  input  logic                 buffered,
  input  logic                 win_has_slave,
  input  logic [CAS_BITS-1:0]  cas_in,
  input  logic [CAS_BITS-1:0]  own_id,
  input  logic [DATA_BITS-1:0] vec_b2,
  input  logic [DATA_BITS-1:0] vec_b3,
  output logic                 data_oe,
  output logic [DATA_BITS-1:0] data_out,
  output logic                 buf_en
);
  logic                 id_match;
  logic                 drive;
  logic [DATA_BITS-1:0] byte_val;

  assign id_match = (cas_in == own_id);

  always_comb begin
    drive    = 1'b0;
    byte_val = '0;
    unique case (byte_idx)
      IDX_FIRST: begin
        drive    = is_master & ~mode86;
        byte_val = DATA_BITS'(CALL_OP);
      end
      IDX_SECOND: begin
        drive    = is_master ? ~win_has_slave : id_match;
        byte_val = vec_b2;
      end
      IDX_THIRD: begin
        drive    = ~mode86 & (is_master ? ~win_has_slave : id_match);
        byte_val = vec_b3;
      end
      default: begin
        drive    = 1'b0;
        byte_val = '0;
      end
    endcase
  end

  assign data_oe  = ~ack_n & drive;
  assign data_out = data_oe ? byte_val : '0;
  assign buf_en   = buffered & data_oe;

  // R8: a slave whose identity is not on the bus stays off the data bus
  assert_slave_nomatch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_master && !id_match) |-> !data_oe);

  // R11: an idle data bus carries zero
  assert_data_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> data_out == '0);

  // R9: the buffer opens only in buffered operation during a strobe
  assert_buf_role_R9: assert property (@(posedge clk) disable iff (!rst_n)
    buf_en |-> (buffered && !ack_n));

  // R6: nothing is driven on the first pulse of the 86 sequence
  assert_first86_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode86 && byte_idx == IDX_FIRST) |-> !data_oe);
endmodule

// File: rtl/cascade_ack_seq.sv
module cascade_ack_seq
  import cas_ack_pkg::*;
#(
  parameter int unsigned CAS_BITS  = CAS_W,
  parameter int unsigned DATA_BITS = DATA_W,
  localparam int unsigned NUM_IN   = 1 << CAS_BITS
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 init_wr,
  input  logic                 ack_n,
  input  logic                 mode86,
  input  logic                 is_master,
  input  logic                 buffered,
  input  logic [NUM_IN-1:0]    slave_mask,
  input  logic [CAS_BITS-1:0]  own_id,
  input  logic [CAS_BITS-1:0]  win_level,
  input  logic [CAS_BITS-1:0]  cas_in,
  input  logic [DATA_BITS-1:0] vec_b2,
  input  logic [DATA_BITS-1:0] vec_b3,
  output logic [CAS_BITS-1:0]  cas_out,
  output logic                 data_oe,
  output logic [DATA_BITS-1:0] data_out,
  output logic                 buf_en
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       ack_fall, ack_rise, seq_done, win_has_slave;
  byte_idx_t  byte_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ack_pulse_tracker u_track (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ack_n    (ack_n),
    .init_wr  (init_wr),
    .mode86   (mode86),
    .ack_fall (ack_fall),
    .ack_rise (ack_rise),
    .byte_idx (byte_idx),
    .seq_done (seq_done)
  );

  cas_addr_master #(.CAS_BITS(CAS_BITS)) u_cas (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .is_master     (is_master),
    .init_wr       (init_wr),
    .ack_fall      (ack_fall),
    .ack_rise      (ack_rise),
    .seq_done      (seq_done),
    .byte_idx      (byte_idx),
    .win_level     (win_level),
    .slave_mask    (slave_mask),
    .cas_out       (cas_out),
    .win_has_slave (win_has_slave)
  );

  ack_data_driver #(.CAS_BITS(CAS_BITS), .DATA_BITS(DATA_BITS)) u_drv (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .ack_n         (ack_n),
    .byte_idx      (byte_idx),
    .mode86        (mode86),
    .is_master     (is_master),
    .buffered      (buffered),
    .win_has_slave (win_has_slave),
    .cas_in        (cas_in),
    .own_id        (own_id),
    .vec_b2        (vec_b2),
    .vec_b3        (vec_b3),
    .data_oe       (data_oe),
    .data_out      (data_out),
    .buf_en        (buf_en)
  );

  // R5: an 80/85 master opens every sequence with the CALL opcode
  assert_call_first_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (is_master && !mode86 && !ack_n && byte_idx == IDX_FIRST)
      |-> (data_oe && data_out == DATA_BITS'(CALL_OP)));

  // R7: a master yields bytes 2 and 3 to an attached slave
  assert_master_yield_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (is_master && win_has_slave && byte_idx != IDX_FIRST) |-> !data_oe);
endmodule

// File: tb/cascade_ack_seq_test.sv
module cascade_ack_seq_test;
  logic       clk = 1'b0;
  logic       rst_n, init_wr, ack_n, mode86, is_master, buffered;
  logic [7:0] slave_mask, vec_b2, vec_b3, data_out;
  logic [2:0] own_id, win_level, cas_in, cas_out;
  logic       data_oe, buf_en;
  int         n_checks = 0;
  int         n_fail = 0;
  bit         finished = 1'b0;

  always #2 clk = ~clk;

  cascade_ack_seq uut (
    .clk(clk), .rst_n(rst_n), .init_wr(init_wr), .ack_n(ack_n),
    .mode86(mode86), .is_master(is_master), .buffered(buffered),
    .slave_mask(slave_mask), .own_id(own_id), .win_level(win_level),
    .cas_in(cas_in), .vec_b2(vec_b2), .vec_b3(vec_b3),
    .cas_out(cas_out), .data_oe(data_oe), .data_out(data_out), .buf_en(buf_en)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_oe(input int k);
    logic has = slave_mask[win_level];
    logic mt  = (cas_in == own_id);
    case (k)
      1: return is_master && !mode86;
      2: return is_master ? !has : mt;
      3: return !mode86 && (is_master ? !has : mt);
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [7:0] exp_data(input int k);
    if (!exp_oe(k)) return 8'h00;
    case (k)
      1: return 8'hCD;
      2: return vec_b2;
      default: return vec_b3;
    endcase
  endfunction

  function automatic logic [2:0] exp_cas(input int k, input int n);
    return (is_master && slave_mask[win_level] && k < n) ? win_level : 3'd0;
  endfunction

  task automatic one_pulse(input int k, input int n);
    @(negedge clk); ack_n = 1'b0;
    @(negedge clk);
    chk($sformatf("R5/R6/R7/R8 oe byte%0d", k), {7'd0, data_oe}, {7'd0, exp_oe(k)});
    chk($sformatf("R5/R6/R8/R11 data byte%0d", k), data_out, exp_data(k));
    chk($sformatf("R9 buf_en byte%0d", k), {7'd0, buf_en}, {7'd0, buffered & exp_oe(k)});
    ack_n = 1'b1;
    @(negedge clk);
    chk($sformatf("R2/R3/R4 cas after byte%0d", k), {5'd0, cas_out}, {5'd0, exp_cas(k, n)});
  endtask

  task automatic run_seq();
    int n = mode86 ? 2 : 3;
    for (int k = 1; k <= n; k++) one_pulse(k, n);
  endtask

  task automatic cfg(input logic m86, input logic mst, input logic buf_i,
                     input logic [7:0] msk, input logic [2:0] win,
                     input logic [2:0] oid, input logic [2:0] cin);
    @(negedge clk);
    mode86 = m86; is_master = mst; buffered = buf_i; slave_mask = msk;
    win_level = win; own_id = oid; cas_in = cin;
    vec_b2 = 8'($urandom); vec_b3 = 8'($urandom);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; init_wr = 1'b0; ack_n = 1'b1; mode86 = 1'b0; is_master = 1'b1;
    buffered = 1'b0; slave_mask = 8'h00; own_id = 3'd0; win_level = 3'd0;
    cas_in = 3'd0; vec_b2 = 8'h00; vec_b3 = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 cas_out", {5'd0, cas_out}, 8'd0);
    chk("R1 data_oe", {7'd0, data_oe}, 8'd0);
    chk("R1 data_out", data_out, 8'd0);
    chk("R1 buf_en", {7'd0, buf_en}, 8'd0);

    // R2 R3 R7: master, slave on input 5, 80/85
    cfg(1'b0, 1'b1, 1'b1, 8'h20, 3'd5, 3'd0, 3'd0); run_seq();
    // R4 R6: master, no slave, 86 mode
    cfg(1'b1, 1'b1, 1'b0, 8'h20, 3'd2, 3'd0, 3'd0); run_seq();
    // R6 R9: master, no slave, 80/85 buffered
    cfg(1'b0, 1'b1, 1'b1, 8'h00, 3'd7, 3'd0, 3'd0); run_seq();
    // R8: slave match 80/85, then mismatch, then match 86
    cfg(1'b0, 1'b0, 1'b1, 8'h00, 3'd0, 3'd3, 3'd3); run_seq();
    cfg(1'b0, 1'b0, 1'b1, 8'h00, 3'd0, 3'd3, 3'd4); run_seq();
    cfg(1'b1, 1'b0, 1'b0, 8'h00, 3'd0, 3'd6, 3'd6); run_seq();
    // R2: slave on input 0
    cfg(1'b0, 1'b1, 1'b0, 8'h01, 3'd0, 3'd0, 3'd0); run_seq();

    // R10: init write after first pulse restarts the sequence
    cfg(1'b0, 1'b1, 1'b0, 8'h08, 3'd3, 3'd0, 3'd0);
    one_pulse(1, 3);
    @(negedge clk); init_wr = 1'b1;
    @(negedge clk); init_wr = 1'b0;
    chk("R10 cas cleared by init", {5'd0, cas_out}, 8'd0);
    run_seq();

    for (int i = 0; i < 300; i++) begin
      logic [2:0] oid = 3'($urandom);
      cfg(1'($urandom), 1'($urandom), 1'($urandom), 8'($urandom), 3'($urandom),
          oid, ($urandom % 2) ? oid : 3'($urandom));
      run_seq();
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule